// File: doc/BRIEF.md
# Split External Data Memory Router

This block sits between an 8-bit processor's data-memory port and two possible homes for each byte: an 8 KB internal RAM and an external memory bus. Every CPU access carries a 16-bit address, so the processor sees a 64 KB data space. A two-bit map selector picks the home for each access. In internal-only mode the RAM repeats every 8 KB across the whole space. In external-only mode every access goes to the pins. In split mode the lowest 8 KB is internal and everything above it is external.

The external bus runs in one of two shapes, chosen by a single control bit. In the shared shape, the low address byte is presented on the combined data lines during a one-cycle latch-enable pulse, and the same lines then carry the data. In the separate shape, all sixteen address bits have their own pins and the latch enable stays low. Both control inputs are taken at the moment a request is accepted and are then held for the whole transfer. The shared lines are modelled as an output value, an output enable and an input value.

Top module: `dmem_router`

## Requirements
- R1: In internal-only mode (map code 0) every access goes to the RAM and uses only address bits [12:0]. As a result, addresses 0x0010, 0x2010 and 0xE010 all reach the same byte, and no external strobe occurs.
- R2: In external-only mode (map code 1) every access, including one below 0x2000, runs an external cycle. An external write never changes the internal RAM.
- R3: In split mode (map code 2) addresses 0x0000 to 0x1FFF go to the RAM and addresses 0x2000 to 0xFFFF go to the external bus.
- R4: In shared-bus mode (bus bit 1) an external access first spends one cycle with latch enable high, the address low byte on the shared data lines with their output enable set, and the high byte on the upper address pins. The strobe phase follows.
- R5: In separate-bus mode (bus bit 0) latch enable stays low. The full address is on the upper and lower address pins during the whole external cycle, and the strobe starts in the cycle right after acceptance.
- R6: An internal access completes in one cycle: done is high, for one cycle, in the cycle after the request is accepted.
- R7: An external access holds the read strobe (for a read) or the write strobe (for a write) low for exactly two cycles. Done then pulses high for one cycle, and all bus pins return to idle (strobes high, latch enable low, output enable low, address and data 0).
- R8: Read data returned with done comes only from the target that served the access. A write reaches only that target.
- R9: During the strobe phase of an external read the shared-line output enable is low. During the strobe phase of a write it is high, and the write data is on the lines.
- R10: A change of map mode or bus shape during an external cycle does not alter that cycle. The next accepted request uses the new setting.
- R11: A request that arrives while an external cycle is in progress, before its done cycle, is ignored. A request in the done cycle itself is accepted.
- R12: After reset, done is low, both strobes are high, latch enable and output enable are low, and the address and data pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_map_mode | input | 2 | 0 internal only, 1 external only, 2 or 3 split |
| cfg_bus_mux | input | 1 | 1 shared address/data lines, 0 separate lines |
| cpu_req | input | 1 | Access request strobe |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with done on a read |
| cpu_done | output | 1 | One-cycle completion pulse |
| ext_addr_hi | output | 8 | Upper address pins |
| ext_addr_lo | output | 8 | Lower address pins (separate-bus mode) |
| ext_ad_out | output | 8 | Shared data lines, driven value |
| ext_ad_oe | output | 1 | Shared data lines output enable |
| ext_ad_in | input | 8 | Shared data lines, sampled value |
| ext_ale | output | 1 | Address latch enable |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |

## Verification
Two things can happen in the same cycle. A new request can arrive in the done cycle of an external transfer, so the end of one access and the acceptance of the next coincide. A configuration change can land in the middle of an external transfer. The bench provokes the first by holding requests on every cycle across several external and internal accesses. It provokes the second by flipping the map mode and bus shape in the cycle after acceptance. A behavioural model decides from its own busy state which requests are taken, and it queues the exact pin values for every following cycle. Those values are compared on every clock, so a request taken too early, too late or twice shows up as a pin mismatch.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    localparam int unsigned CPU_AW = 16;
    localparam int unsigned CPU_DW = 8;

    typedef enum logic [1:0] {
        MAP_INTERNAL = 2'd0,
        MAP_EXTERNAL = 2'd1,
        MAP_SPLIT    = 2'd2,
        MAP_SPLIT_B  = 2'd3
    } map_mode_e;

    typedef struct packed {
        logic              we;
        logic              mux;
        logic [CPU_AW-1:0] addr;
        logic [CPU_DW-1:0] wdata;
    } xfer_t;

    function automatic logic route_to_ext(map_mode_e m, logic [CPU_AW-1:0] a,
                                          int unsigned ram_aw);
        logic r;
        case (m)
            MAP_INTERNAL: r = 1'b0;
            MAP_EXTERNAL: r = 1'b1;
            default:      r = ((a >> ram_aw) != '0);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/dmr_decode.sv
module dmr_decode
    import dmr_pkg::*;
#(
    parameter int unsigned RAM_AW = 13
) (
    input  map_mode_e         mode,
    input  logic [CPU_AW-1:0] addr,
    output logic              to_ext
);
    always_comb to_ext = route_to_ext(mode, addr, RAM_AW);
endmodule

// File: rtl/dmr_iram.sv
module dmr_iram
    import dmr_pkg::*;
#(
    parameter int unsigned RAM_AW = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [RAM_AW-1:0] addr,
    input  logic [CPU_DW-1:0] wdata,
    output logic [CPU_DW-1:0] rdata,
    output logic              ack
);
    localparam int unsigned DEPTH = 1 << RAM_AW;

    logic [CPU_DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            rdata <= mem[addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ack <= 1'b0;
        else     ack <= en;
    end

    p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        en |=> ack);
    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(en));
endmodule

// File: rtl/dmr_ext_seq.sv
module dmr_ext_seq
    import dmr_pkg::*;
#(
    parameter int unsigned STB_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_t             xfer_in,
    input  logic [CPU_DW-1:0] ad_in,
    output logic              busy,
    output logic              done,
    output logic [CPU_DW-1:0] rdata,
    output logic [7:0]        addr_hi,
    output logic [7:0]        addr_lo,
    output logic [CPU_DW-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n
);
    localparam int unsigned CW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;

    typedef enum logic [1:0] { X_IDLE, X_ALE, X_STB } xstate_e;

    xstate_e         st;
    xfer_t           txn;
    logic [CW-1:0]   cnt;
    logic            in_ale, in_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= X_IDLE;
            txn   <= '0;
            cnt   <= '0;
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                X_IDLE: if (start) begin
                    txn <= xfer_in;
                    cnt <= '0;
                    st  <= xfer_in.mux ? X_ALE : X_STB;
                end
                X_ALE: begin
                    cnt <= '0;
                    st  <= X_STB;
                end
                X_STB: begin
                    if (cnt == CW'(STB_CYC - 1)) begin
                        st   <= X_IDLE;
                        done <= 1'b1;
                        if (!txn.we) rdata <= ad_in;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= X_IDLE;
            endcase
        end
    end

    always_comb begin
        in_ale  = (st == X_ALE);
        in_stb  = (st == X_STB);
        busy    = (st != X_IDLE);
        ale     = in_ale;
        rd_n    = !(in_stb && !txn.we);
        wr_n    = !(in_stb && txn.we);
        addr_hi = busy ? txn.addr[15:8] : 8'h00;
        addr_lo = (busy && !txn.mux) ? txn.addr[7:0] : 8'h00;
        ad_oe   = in_ale || (in_stb && txn.we);
        if (in_ale)                 ad_out = txn.addr[7:0];
        else if (in_stb && txn.we)  ad_out = txn.wdata;
        else                        ad_out = '0;
    end

    p_ale_then_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        ale |=> (!rd_n || !wr_n));
    p_sep_no_ale_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !txn.mux) |-> !ale);
    p_done_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(!rd_n || !wr_n));
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    p_read_released_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);
    p_hold_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(addr_hi));
endmodule

// File: rtl/dmem_router.sv
module dmem_router
    import dmr_pkg::*;
#(
    parameter int unsigned RAM_AW  = 13,
    parameter int unsigned STB_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_map_mode,
    input  logic        cfg_bus_mux,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        cpu_done,
    output logic [7:0]  ext_addr_hi,
    output logic [7:0]  ext_addr_lo,
    output logic [7:0]  ext_ad_out,
    output logic        ext_ad_oe,
    input  logic [7:0]  ext_ad_in,
    output logic        ext_ale,
    output logic        ext_rd_n,
    output logic        ext_wr_n
);
    map_mode_e         mode;
    logic              to_ext, ext_busy, accept, iram_en, ext_start;
    logic              iram_ack, ext_done;
    logic [CPU_DW-1:0] iram_q, ext_q;
    xfer_t             xfer;

    always_comb begin
        mode      = map_mode_e'(cfg_map_mode);
        accept    = cpu_req && !ext_busy;
        iram_en   = accept && !to_ext;
        ext_start = accept && to_ext;
        xfer      = '{we: cpu_we, mux: cfg_bus_mux, addr: cpu_addr, wdata: cpu_wdata};
        cpu_done  = iram_ack || ext_done;
        cpu_rdata = iram_ack ? iram_q : ext_q;
    end

    dmr_decode #(.RAM_AW(RAM_AW)) u_decode (
        .mode   (mode),
        .addr   (cpu_addr),
        .to_ext (to_ext)
    );

    dmr_iram #(.RAM_AW(RAM_AW)) u_iram (
        .clk   (clk),
        .rst   (rst),
        .en    (iram_en),
        .we    (cpu_we),
        .addr  (cpu_addr[RAM_AW-1:0]),
        .wdata (cpu_wdata),
        .rdata (iram_q),
        .ack   (iram_ack)
    );

    dmr_ext_seq #(.STB_CYC(STB_CYC)) u_ext (
        .clk     (clk),
        .rst     (rst),
        .start   (ext_start),
        .xfer_in (xfer),
        .ad_in   (ext_ad_in),
        .busy    (ext_busy),
        .done    (ext_done),
        .rdata   (ext_q),
        .addr_hi (ext_addr_hi),
        .addr_lo (ext_addr_lo),
        .ad_out  (ext_ad_out),
        .ad_oe   (ext_ad_oe),
        .ale     (ext_ale),
        .rd_n    (ext_rd_n),
        .wr_n    (ext_wr_n)
    );

    p_internal_only_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg_map_mode == 2'd0) |-> !ext_start);
    p_external_only_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_map_mode == 2'd1) |-> !iram_en);
    p_split_low_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !ext_busy && cfg_map_mode[1] && cpu_addr < 16'h2000) |-> iram_en);
    p_one_target_r8: assert property (@(posedge clk) disable iff (rst)
        !(iram_ack && ext_done));
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        (ext_busy && cpu_req) |=> !iram_ack);
    p_reset_idle_r12: assert property (@(posedge clk)
        $past(rst) |-> (!cpu_done && ext_rd_n && ext_wr_n && !ext_ale && !ext_ad_oe));
endmodule

// File: tb/dmem_router_tb.sv
`timescale 1ns/100ps
module dmem_router_tb;
    typedef struct packed {
        logic       busy, ale, rd_n, wr_n, oe;
        logic [7:0] ad, hi, lo;
        logic       done, chk;
        logic [7:0] rd;
    } exp_t;

    logic clk = 0, rst = 1;
    logic [1:0] cfg_map_mode = 0;
    logic cfg_bus_mux = 1, cpu_req = 0, cpu_we = 0;
    logic [15:0] cpu_addr = 0;
    logic [7:0] cpu_wdata = 0, ext_ad_in = 0;
    logic [7:0] cpu_rdata, ext_addr_hi, ext_addr_lo, ext_ad_out;
    logic cpu_done, ext_ad_oe, ext_ale, ext_rd_n, ext_wr_n;

    int total = 0, bad = 0;
    bit finished = 0;
    string scen = "R12 reset";
    exp_t q[$];
    bit cur_busy = 0;
    logic [7:0] iram_m [8192];
    logic [7:0] ext_m [int];

    always #2.5 clk = ~clk;

    dmem_router u_dut (.*);

    function automatic logic [7:0] ext_val(logic [15:0] a);
        if (ext_m.exists(int'(a))) return ext_m[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic exp_t idle_e();
        exp_t e = '0;
        e.rd_n = 1; e.wr_n = 1;
        return e;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s [%s] act=%0h exp=%0h t=%0t", tag, scen, act, exp, $time);
        end
    endtask

    task automatic step();
        exp_t e;
        @(posedge clk); #2;
        e = (q.size() > 0) ? q.pop_front() : idle_e();
        chk(cpu_done === e.done, "R6/R7 done", cpu_done, e.done);
        chk(ext_ale === e.ale, "R4 ale", ext_ale, e.ale);
        chk(ext_rd_n === e.rd_n && ext_wr_n === e.wr_n, "R7 strobes",
            {ext_rd_n, ext_wr_n}, {e.rd_n, e.wr_n});
        chk(ext_ad_oe === e.oe, "R9 oe", ext_ad_oe, e.oe);
        chk(ext_ad_out === e.ad, "R4/R9 ad_out", ext_ad_out, e.ad);
        chk(ext_addr_hi === e.hi && ext_addr_lo === e.lo, "R5 addr pins",
            {ext_addr_hi, ext_addr_lo}, {e.hi, e.lo});
        if (e.chk) chk(cpu_rdata === e.rd, "R8 rdata", cpu_rdata, e.rd);
        cur_busy = e.busy;
    endtask

    task automatic access(bit we, logic [15:0] a, logic [7:0] d);
        bit ext;
        exp_t e;
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (!cur_busy) begin
            ext = (cfg_map_mode == 2'd1) || (cfg_map_mode[1] && a >= 16'h2000);
            if (!ext) begin
                e = idle_e(); e.done = 1; e.chk = !we; e.rd = iram_m[a[12:0]];
                if (we) iram_m[a[12:0]] = d;
                q.push_back(e);
            end else begin
                if (!we) ext_ad_in = ext_val(a);
                if (cfg_bus_mux) begin
                    e = idle_e(); e.busy = 1; e.ale = 1; e.oe = 1;
                    e.ad = a[7:0]; e.hi = a[15:8];
                    q.push_back(e);
                end
                for (int i = 0; i < 2; i++) begin
                    e = idle_e(); e.busy = 1; e.hi = a[15:8];
                    e.lo = cfg_bus_mux ? 8'h00 : a[7:0];
                    e.rd_n = we; e.wr_n = !we; e.oe = we; e.ad = we ? d : 8'h00;
                    q.push_back(e);
                end
                e = idle_e(); e.done = 1; e.chk = !we; e.rd = ext_val(a);
                q.push_back(e);
                if (we) ext_m[int'(a)] = d;
            end
        end
        step();
        cpu_req = 0;
    endtask

    task automatic drain();
        while (q.size() > 0 || cur_busy) step();
        step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog [%s] act=0 exp=1", scen);
        finish_run();
    end

    initial begin
        // R12: reset state
        repeat (3) step();
        rst = 0;
        step();

        // R1/R6: internal-only with aliasing
        scen = "R1 R6 internal alias";
        cfg_map_mode = 2'd0; cfg_bus_mux = 1;
        access(1, 16'h0010, 8'h11);
        access(0, 16'h0010, 8'h00);
        access(0, 16'h2010, 8'h00);
        access(0, 16'hE010, 8'h00);
        access(1, 16'hFFFF, 8'h77);
        access(0, 16'h1FFF, 8'h00);
        drain();

        // R3: split mapping, shared bus
        scen = "R3 R4 split shared";
        cfg_map_mode = 2'd2;
        access(0, 16'h1FFF, 8'h00); drain();
        access(1, 16'h2000, 8'h3C); drain();
        access(0, 16'h2000, 8'h00); drain();
        access(0, 16'h0010, 8'h00); drain();
        access(0, 16'hC3A5, 8'h00); drain();

        // R2/R8: external-only leaves RAM untouched
        scen = "R2 R8 external only";
        cfg_map_mode = 2'd1;
        access(1, 16'h0010, 8'hEE); drain();
        access(0, 16'h0010, 8'h00); drain();
        cfg_map_mode = 2'd0;
        access(0, 16'h0010, 8'h00); drain();

        // R5/R9: separate bus
        scen = "R5 R9 separate bus";
        cfg_map_mode = 2'd1; cfg_bus_mux = 0;
        access(1, 16'h1234, 8'h56); drain();
        access(0, 16'hABCD, 8'h00); drain();
        access(0, 16'h1234, 8'h00); drain();

        // R10: configuration flips mid-cycle
        scen = "R10 mid-cycle change";
        cfg_map_mode = 2'd1; cfg_bus_mux = 1;
        access(0, 16'h4321, 8'h00);
        cfg_map_mode = 2'd0; cfg_bus_mux = 0;
        drain();
        access(0, 16'h0010, 8'h00); drain();
        cfg_map_mode = 2'd1;
        access(1, 16'h0F0F, 8'hA1);
        cfg_bus_mux = 1; cfg_map_mode = 2'd2;
        drain();

        // R11: requests every cycle, accepted only when idle
        scen = "R11 back-to-back";
        cfg_map_mode = 2'd1; cfg_bus_mux = 1;
        for (int i = 0; i < 12; i++)
            access(i[0], 16'h5550 + 16'(i), 8'h90 + 8'(i));
        drain();
        cfg_bus_mux = 0;
        for (int i = 0; i < 10; i++)
            access(!i[0], 16'h6660 + 16'(i), 8'h40 + 8'(i));
        drain();
        scen = "R11 R3 split mixed";
        cfg_map_mode = 2'd2; cfg_bus_mux = 1;
        for (int i = 0; i < 10; i++)
            access(0, (i % 3 == 0) ? 16'h8000 + 16'(i) : 16'h1FFF, 8'h00);
        drain();
        for (int i = 0; i < 6; i++)
            access(0, 16'h0010, 8'h00);
        drain();

        finish_run();
    end
endmodule